// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Freeze

This block sits between an instruction fetch unit and a memory port that reads one longword at a time. It holds 32 lines of 16 bytes (four longwords each), with one tag and one valid bit per line. When a fetch misses, the block reads the whole line into a line-fill buffer. The requested word goes back to the fetch unit as soon as its longword arrives. At the end of the fill, the buffer is copied into the array. When the cache is disabled, every fetch becomes a single memory access and the array is left untouched.

A 32-bit control register sets the operating mode. Software can only write it; its contents can be seen only while a debug-mode input is high. It has four bits:

- an enable bit;
- a freeze bit, which keeps valid lines from being replaced while misses are still served through the fill buffer;
- a bit that turns the single-line invalidate command into a no-op;
- a self-clearing invalidate-all bit, which wipes the array one line per cycle while fetches wait.

The single-line invalidate command is a pulse that carries an address.

Top module: `icache_frz`

## Requirements
- R1: After reset, the control register reads as all zeros (in debug mode), so the cache starts disabled, unfrozen and with line invalidation allowed. `f_rdy` and `m_req` are low.
- R2: Control bits are enable = bit 31, invalidation-disable = bit 28, freeze = bit 27 and invalidate-all = bit 24. All other bits are stored as zero. `ctl_rdata` shows the register only while `dbg_mode` is 1 and reads zero otherwise.
- R3: With enable at 0, each fetch causes exactly one memory access. The array is neither read (fresh memory data is returned even for a line that is cached) nor written (a later enabled fetch of the same line misses).
- R4: With enable at 1, a fetch that hits (tag = address bits [31:9], index = bits [8:4], valid set) returns data with no memory access. `f_rdy` is a one-cycle pulse.
- R5: A miss reads the line as four longword accesses at the line base + 0, 4, 8 and 12, in that order. It then allocates the line, so a repeat fetch hits.
- R6: On a miss, `f_rdy` is raised as soon as the longword holding the requested word arrives, while the rest of the fill is still running.
- R7: A fetch is longword-sized unless `f_word` is 1 or address bit 1 is 1; either of these makes it a word-sized access. Word data comes back in `f_data[15:0]` with the upper half zero: the upper half of the longword when bit 1 is 0, the lower half when bit 1 is 1. A disabled word fetch drives `m_word` high.
- R8: With invalidation-disable at 0, an `inv_req` pulse clears the valid bit of the line indexed by `inv_addr[8:4]`.
- R9: With invalidation-disable at 1, an `inv_req` pulse has no effect.
- R10: With freeze at 1, a miss to a line that is already valid still fetches through the buffer and returns correct data, but the stored line is not replaced.
- R11: With freeze at 1, a miss to an invalid line is written into the array.
- R12: Writing 1 to invalidate-all clears every valid bit over 32 cycles, one line per cycle. The bit then clears itself, and fetches stall until it does.
- R13: If an enabled single-line invalidate hits the line being filled, the fill completes and the requested data is returned, but the buffer is discarded instead of written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| dbg_mode | input | 1 | Debug mode; makes the control register visible |
| ctl_rdata | output | 32 | Control register value in debug mode, otherwise zero |
| inv_req | input | 1 | Single-line invalidate pulse |
| inv_addr | input | 32 | Address selecting the line to invalidate |
| f_req | input | 1 | Fetch request, held until `f_rdy` |
| f_addr | input | 32 | Fetch byte address |
| f_word | input | 1 | 1 = word-sized fetch |
| f_rdy | output | 1 | Fetch data valid pulse |
| f_data | output | 32 | Fetch data |
| m_req | output | 1 | Memory read request, held until `m_ack` |
| m_addr | output | 32 | Memory read address |
| m_word | output | 1 | 1 = word-sized memory access |
| m_ack | input | 1 | Memory acknowledge, with data valid |
| m_data | input | 32 | Longword read from memory |

## Verification
Some properties are checked on every cycle:

- a held memory request keeps a stable address;
- `f_rdy` is a single-cycle pulse;
- an enabled line invalidate leaves its line invalid;
- a disabled invalidate leaves all valid bits unchanged;
- a frozen fill over a valid line leaves its tag alone;
- the invalidate-all bit falls only once the array is empty.

Other behaviour can only be shown by the bench's fetch sequences, because it depends on the order of events: hit and miss access counts, the order of line-fill addresses, early delivery of the critical word, word-half selection, bypass freshness, and buffer discard when an invalidate lands during a fill.

// File: rtl/icache_frz.sv
module icache_frz #(
  parameter int AW         = 32,
  parameter int LINES      = 32,
  parameter int LWORDS     = 4,
  parameter int EN_BIT     = 31,
  parameter int NOINV_BIT  = 28,
  parameter int FRZ_BIT    = 27,
  parameter int INVALL_BIT = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [31:0]   ctl_wdata,
  input  logic          dbg_mode,
  output logic [31:0]   ctl_rdata,
  input  logic          inv_req,
  input  logic [AW-1:0] inv_addr,
  input  logic          f_req,
  input  logic [AW-1:0] f_addr,
  input  logic          f_word,
  output logic          f_rdy,
  output logic [31:0]   f_data,
  output logic          m_req,
  output logic [AW-1:0] m_addr,
  output logic          m_word,
  input  logic          m_ack,
  input  logic [31:0]   m_data
);
  localparam int WSEL_W = $clog2(LWORDS);
  localparam int OFF_W  = WSEL_W + 2;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = AW - IDX_W - OFF_W;
  localparam logic [31:0] EN_M     = 32'd1 << EN_BIT;
  localparam logic [31:0] NOINV_M  = 32'd1 << NOINV_BIT;
  localparam logic [31:0] FRZ_M    = 32'd1 << FRZ_BIT;
  localparam logic [31:0] INVALL_M = 32'd1 << INVALL_BIT;
  localparam logic [31:0] CTL_M    = EN_M | NOINV_M | FRZ_M | INVALL_M;

  typedef enum logic [1:0] {S_IDLE, S_BYP, S_FILL, S_FLUSH} st_t;

  st_t                st;
  logic [31:0]        ctrl;
  logic [LINES-1:0]   valid;
  logic [TAG_W-1:0]   tags [LINES];
  logic [31:0]        dmem [LINES*LWORDS];
  logic [31:0]        lfb  [LWORDS];
  logic [AW-1:0]      rq_addr;
  logic               rq_word;
  logic [WSEL_W-1:0]  cnt;
  logic [IDX_W-1:0]   fcnt;
  logic               discard;
  logic               rdy_q;
  logic [31:0]        dat_q;

  function automatic logic [31:0] pick(input logic [31:0] lw, input logic lo, input logic wd);
    if (!wd) return lw;
    return lo ? {16'h0, lw[15:0]} : {16'h0, lw[31:16]};
  endfunction

  wire en     = ctrl[EN_BIT];
  wire frz    = ctrl[FRZ_BIT];
  wire noinv  = ctrl[NOINV_BIT];
  wire invall = ctrl[INVALL_BIT];

  wire [IDX_W-1:0]  f_idx = f_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  f_tag = f_addr[AW-1 -: TAG_W];
  wire [WSEL_W-1:0] f_sel = f_addr[2 +: WSEL_W];
  wire              f_wd  = f_word | f_addr[1];
  wire              hit   = en && valid[f_idx] && (tags[f_idx] == f_tag);

  wire [IDX_W-1:0]  q_idx = rq_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  q_tag = rq_addr[AW-1 -: TAG_W];
  wire [WSEL_W-1:0] q_sel = rq_addr[2 +: WSEL_W];
  wire [TAG_W-1:0]  q_tag_cur = tags[q_idx];
  wire [IDX_W-1:0]  inv_idx = inv_addr[OFF_W +: IDX_W];

  wire inv_go   = inv_req && !noinv;
  wire inv_kill = inv_go && (st == S_FILL) && (inv_idx == q_idx);
  wire last     = (st == S_FILL) && m_ack && (cnt == WSEL_W'(LWORDS-1));
  wire arr_we   = last && !discard && !inv_kill && (!frz || !valid[q_idx]);
  wire accept   = (st == S_IDLE) && f_req && !rdy_q && !invall;
  wire flush_end = (st == S_FLUSH) && (fcnt == IDX_W'(LINES-1));

  logic unused_bits;
  assign unused_bits = ^{inv_addr[AW-1:OFF_W+IDX_W], inv_addr[OFF_W-1:0], f_addr[0], rq_addr[0]};

  assign ctl_rdata = dbg_mode ? ctrl : 32'h0;
  assign f_rdy     = rdy_q;
  assign f_data    = dat_q;
  assign m_req     = (st == S_BYP) || (st == S_FILL);
  assign m_word    = (st == S_BYP) && rq_word;
  assign m_addr    = (st == S_FILL) ? {rq_addr[AW-1:OFF_W], cnt, 2'b00}
                                    : {rq_addr[AW-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (flush_end) begin
      ctrl <= ctrl & ~INVALL_M;
    end else if (ctl_we) begin
      ctrl <= (ctl_wdata & CTL_M) | ((st == S_FLUSH) ? (ctrl & INVALL_M) : 32'h0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rq_addr <= '0;
      rq_word <= 1'b0;
      cnt     <= '0;
      fcnt    <= '0;
      discard <= 1'b0;
      rdy_q   <= 1'b0;
      dat_q   <= '0;
    end else begin
      rdy_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (invall) begin
            st   <= S_FLUSH;
            fcnt <= '0;
          end else if (accept) begin
            rq_addr <= f_addr;
            rq_word <= f_wd;
            cnt     <= '0;
            discard <= 1'b0;
            if (!en) begin
              st <= S_BYP;
            end else if (hit) begin
              rdy_q <= 1'b1;
              dat_q <= pick(dmem[{f_idx, f_sel}], f_addr[1], f_wd);
            end else begin
              st <= S_FILL;
            end
          end
        end
        S_BYP: begin
          if (m_ack) begin
            rdy_q <= 1'b1;
            dat_q <= pick(m_data, rq_addr[1], rq_word);
            st    <= S_IDLE;
          end
        end
        S_FILL: begin
          if (inv_kill) discard <= 1'b1;
          if (m_ack) begin
            lfb[cnt] <= m_data;
            cnt      <= cnt + 1'b1;
            if (cnt == q_sel) begin
              rdy_q <= 1'b1;
              dat_q <= pick(m_data, rq_addr[1], rq_word);
            end
            if (last) st <= S_IDLE;
          end
        end
        S_FLUSH: begin
          fcnt <= fcnt + 1'b1;
          if (flush_end) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
    end else begin
      if (st == S_FLUSH) valid[fcnt] <= 1'b0;
      if (arr_we) valid[q_idx] <= 1'b1;
      if (inv_go) valid[inv_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (arr_we) begin
      tags[q_idx] <= q_tag;
      for (int i = 0; i < LWORDS; i++)
        dmem[{q_idx, i[WSEL_W-1:0]}] <= (i == LWORDS-1) ? m_data : lfb[i];
    end
  end

  // R5
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_ack |=> m_req && $stable(m_addr));

  // R4
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_rdy |=> !f_rdy);

  // R8
  line_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req && !noinv |=> !valid[$past(inv_idx)]);

  // R9
  noinv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req && noinv && st == S_IDLE |=> valid == $past(valid));

  // R3
  byp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_BYP && !inv_req |=> valid == $past(valid));

  // R10
  frz_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_FILL && frz && valid[q_idx] |=> $stable(q_tag_cur));

  // R12
  flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(invall) |-> valid == '0);
endmodule

// File: tb/sim_icache_frz.sv
`timescale 1ns/1ps
module sim_icache_frz;
  logic        clk = 0, rst_n = 0;
  logic        ctl_we = 0, dbg_mode = 0, inv_req = 0, f_req = 0, f_word = 0;
  logic [31:0] ctl_wdata = 0, inv_addr = 0, f_addr = 0;
  logic [31:0] ctl_rdata, f_data, m_addr, m_data;
  logic        f_rdy, m_req, m_word, m_ack;
  logic [7:0]  gen = 8'h01;
  int          checks = 0, fails = 0, acc_cnt = 0;
  logic [31:0] alog [4];
  logic        wlog;
  bit          done = 0;

  always #2.5 clk = ~clk;

  icache_frz u0 (.clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dbg_mode(dbg_mode), .ctl_rdata(ctl_rdata), .inv_req(inv_req), .inv_addr(inv_addr),
    .f_req(f_req), .f_addr(f_addr), .f_word(f_word), .f_rdy(f_rdy), .f_data(f_data),
    .m_req(m_req), .m_addr(m_addr), .m_word(m_word), .m_ack(m_ack), .m_data(m_data));

  function automatic logic [31:0] memval(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ {gen, 24'h3C5A96};
  endfunction

  function automatic logic [31:0] expv(input logic [31:0] a, input logic w);
    logic [31:0] lw;
    lw = memval(a);
    if (!(w | a[1])) return lw;
    return a[1] ? {16'h0, lw[15:0]} : {16'h0, lw[31:16]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ack <= 1'b0;
      m_data <= '0;
    end else begin
      m_ack <= m_req && !m_ack;
      if (m_req && !m_ack) begin
        m_data <= memval(m_addr);
        alog[acc_cnt % 4] <= m_addr;
        wlog <= m_word;
        acc_cnt <= acc_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic ctl_write(input logic [31:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic ctl_read(output logic [31:0] v);
    @(negedge clk); dbg_mode = 1; #1 v = ctl_rdata; dbg_mode = 0;
  endtask

  task automatic inval(input logic [31:0] a);
    @(negedge clk); inv_req = 1; inv_addr = a;
    @(negedge clk); inv_req = 0;
  endtask

  task automatic fetch(input logic [31:0] a, input logic w, output logic [31:0] d,
                       output int accs, output int cyc, output logic mr);
    int a0;
    a0 = acc_cnt;
    cyc = 0;
    @(negedge clk); f_addr = a; f_word = w; f_req = 1;
    do begin @(posedge clk); #1; cyc++; end while (!f_rdy);
    d = f_data; mr = m_req; f_req = 0;
    while (m_req) begin @(posedge clk); #1; end
    accs = acc_cnt - a0;
  endtask

  localparam logic [35:0] VEC [8] = '{
    {32'h0000_1000, 1'b0, 3'd4},
    {32'h0000_1004, 1'b0, 3'd0},
    {32'h0000_100E, 1'b0, 3'd0},
    {32'h0000_1208, 1'b0, 3'd4},
    {32'h0000_1000, 1'b1, 3'd4},
    {32'h0000_2010, 1'b0, 3'd4},
    {32'h0000_2012, 1'b0, 3'd0},
    {32'h0000_201C, 1'b0, 3'd0}
  };

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d, r;
    int accs, cyc;
    logic mr;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 f_rdy", {31'h0, f_rdy}, 32'h0);
    chk("R1 m_req", {31'h0, m_req}, 32'h0);
    @(negedge clk); rst_n = 1;
    ctl_read(r);
    chk("R1 ctrl", r, 32'h0);

    // R2 visibility and masking
    ctl_write(32'h8000_0000);
    @(negedge clk); #1 chk("R2 hidden", ctl_rdata, 32'h0);
    ctl_read(r); chk("R2 enable", r, 32'h8000_0000);
    ctl_write(32'h7EFF_FFFF);
    ctl_read(r); chk("R2 mask", r, 32'h1800_0000);
    ctl_write(32'h0);

    // R3 disabled: one access each, array untouched; R7 word sizing
    fetch(32'h3000, 0, d, accs, cyc, mr);
    chk("R3 byp acc", accs, 1); chk("R3 byp data", d, expv(32'h3000, 0));
    chk("R7 byp long size", {31'h0, wlog}, 32'h0);
    fetch(32'h3006, 0, d, accs, cyc, mr);
    chk("R7 odd word data", d, expv(32'h3006, 0));
    chk("R7 odd word size", {31'h0, wlog}, 32'h1);
    ctl_write(32'h8000_0000);
    fetch(32'h3000, 0, d, accs, cyc, mr);
    chk("R3 not written", accs, 4);
    gen = 8'h02;
    ctl_write(32'h0);
    fetch(32'h3000, 0, d, accs, cyc, mr);
    chk("R3 not read", d, expv(32'h3000, 0));
    ctl_write(32'h8000_0000);

    // R4 hits, R5 misses, R7 halves: vector table
    for (int i = 0; i < 8; i++) begin
      fetch(VEC[i][35:4], VEC[i][3], d, accs, cyc, mr);
      chk(VEC[i][2:0] == 0 ? "R4 hit acc" : "R5 miss acc", accs, {29'h0, VEC[i][2:0]});
      chk("R7 vec data", d, expv(VEC[i][35:4], VEC[i][3]));
    end

    // R5 fill order
    fetch(32'h5008, 0, d, accs, cyc, mr);
    for (int k = 0; k < 4; k++)
      chk("R5 fill addr", alog[(acc_cnt - 4 + k) % 4], 32'h5000 + 32'(4 * k));

    // R6 early return
    fetch(32'h7000, 0, d, accs, cyc, mr);
    chk("R6 early rdy", {31'h0, mr}, 32'h1);
    chk("R6 data", d, expv(32'h7000, 0));

    // R8 single-line invalidate
    fetch(32'h7004, 0, d, accs, cyc, mr); chk("R8 pre hit", accs, 0);
    inval(32'h9000);
    fetch(32'h7004, 0, d, accs, cyc, mr); chk("R8 after inv", accs, 4);

    // R9 invalidation disabled
    ctl_write(32'h9000_0000);
    inval(32'h7000);
    fetch(32'h7000, 0, d, accs, cyc, mr); chk("R9 no effect", accs, 0);

    // R10 freeze over a valid line
    ctl_write(32'h8800_0000);
    fetch(32'h7200, 0, d, accs, cyc, mr);
    chk("R10 miss acc", accs, 4); chk("R10 data", d, expv(32'h7200, 0));
    fetch(32'h7200, 0, d, accs, cyc, mr); chk("R10 not stored", accs, 4);
    fetch(32'h7000, 0, d, accs, cyc, mr); chk("R10 old kept", accs, 0);

    // R11 freeze into an invalid line
    fetch(32'h4030, 0, d, accs, cyc, mr); chk("R11 miss", accs, 4);
    fetch(32'h4030, 0, d, accs, cyc, mr); chk("R11 stored", accs, 0);

    // R12 invalidate-all
    ctl_write(32'h8100_0000);
    fetch(32'h4030, 0, d, accs, cyc, mr);
    chk("R12 refill", accs, 4);
    chk("R12 stall", {31'h0, cyc >= 32}, 32'h1);
    ctl_read(r); chk("R12 selfclear", r, 32'h8000_0000);
    fetch(32'h2010, 0, d, accs, cyc, mr); chk("R12 all cleared", accs, 4);

    // R13 invalidate during fill
    fork
      fetch(32'h6050, 0, d, accs, cyc, mr);
      begin repeat (3) @(posedge clk); inval(32'h6050); end
    join
    chk("R13 data", d, expv(32'h6050, 0));
    fetch(32'h6050, 0, d, accs, cyc, mr); chk("R13 discarded", accs, 4);

    summary();
  end
endmodule